// File: doc/BRIEF.md
# Decode-Stage Stall and Flush Controller

This block decides, every cycle, whether a five-stage integer pipeline that resolves branches in decode may advance. It looks at the instruction in decode and at the two stages ahead of it, ID/EX and EX/MEM. From what it sees, it either lets fetch and decode advance, or holds them and sends a bubble into execute. When a branch in decode resolves taken, it also clears the instruction that was just fetched.

The controller holds no state. A multi-cycle stall comes from the pipeline contents as they move. A load directly ahead of a dependent branch blocks decode once while the load sits in ID/EX, and a second time while it sits in EX/MEM. After that, the loaded value can be forwarded. Forwarding muxes, the register file and the branch comparator are outside the block. The comparator's result arrives on `br_taken`.

All control outputs are active high. While `rst` is high, every output is held at its advancing value.

Top module: `hazard_ctrl`

## Requirements
- R1: While `rst` is 1, `pc_we`=1, `ifid_we`=1, `idex_bubble`=0 and `ifid_flush`=0, whatever the other inputs are.
- R2: A load-use stall occurs when `idex_mem_rd`=1, `idex_reg_wr`=1, `idex_dst`≠0 and `idex_dst` equals `dec_rs` or `dec_rt`. A stall means `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1 in the same cycle.
- R3: For a non-branch instruction in decode, a load in EX/MEM causes no stall, because its value is forwarded. A load-use stall therefore lasts one cycle.
- R4: A branch in decode stalls when ID/EX holds a non-load (`idex_mem_rd`=0) with `idex_reg_wr`=1 and a nonzero `idex_dst` equal to `dec_rs` or `dec_rt`. The same producer causes no stall for a non-branch.
- R5: A branch in decode stalls when EX/MEM holds a load (`exmem_mem_rd`=1, `exmem_reg_wr`=1) whose nonzero `exmem_dst` equals `dec_rs` or `dec_rt`.
- R6: A branch directly after a load that feeds it is held for exactly two cycles. It advances in the third cycle, once the load has left EX/MEM.
- R7: A non-load producer in EX/MEM never stalls decode, even for a branch.
- R8: A destination register of 0 never causes a stall.
- R9: A stage whose register-write flag is 0 never causes a stall, even if its memory-read flag is 1.
- R10: A branch in decode with `br_taken`=1 and no stall drives `ifid_flush`=1, while `pc_we` and `ifid_we` stay 1.
- R11: `br_taken` is ignored while decode is stalled, and whenever decode holds no branch. In both cases `ifid_flush`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; used only to sample the checks |
| rst | input | 1 | Synchronous reset, active high; forces outputs to advance |
| dec_rs | input | REG_W | First source register of the instruction in decode |
| dec_rt | input | REG_W | Second source register of the instruction in decode |
| dec_is_branch | input | 1 | Instruction in decode is a conditional branch |
| br_taken | input | 1 | Comparator outcome for the branch in decode |
| idex_mem_rd | input | 1 | ID/EX instruction reads memory (load) |
| idex_reg_wr | input | 1 | ID/EX instruction writes a register |
| idex_dst | input | REG_W | Destination register of the ID/EX instruction |
| exmem_mem_rd | input | 1 | EX/MEM instruction reads memory (load) |
| exmem_reg_wr | input | 1 | EX/MEM instruction writes a register |
| exmem_dst | input | REG_W | Destination register of the EX/MEM instruction |
| pc_we | output | 1 | PC may load its next value |
| ifid_we | output | 1 | IF/ID register may load |
| idex_bubble | output | 1 | Zero all control fields written into ID/EX |
| ifid_flush | output | 1 | Clear the IF/ID register at the next edge |

## Verification
The assertions assume that the inputs describe a consistent pipeline state. They also assume the inputs hold steady across each rising edge, since the outputs are combinational and the properties sample them there. The bench changes inputs only on falling edges, and it feeds only flag combinations a real pipeline can produce, apart from the deliberate R9 vectors that set a read flag without a write flag. The R6 sequence is played as consecutive cycles, with the load moving from ID/EX to EX/MEM and a bubble taking its place.

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] dec_rs,
  input  logic [REG_W-1:0] dec_rt,
  input  logic             dec_is_branch,
  input  logic             br_taken,
  input  logic             idex_mem_rd,
  input  logic             idex_reg_wr,
  input  logic [REG_W-1:0] idex_dst,
  input  logic             exmem_mem_rd,
  input  logic             exmem_reg_wr,
  input  logic [REG_W-1:0] exmem_dst,
  output logic             pc_we,
  output logic             ifid_we,
  output logic             idex_bubble,
  output logic             ifid_flush
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic idex_hit, exmem_hit;
  logic load_use, br_alu, br_load2, hold;

  assign idex_hit  = idex_reg_wr  && (idex_dst  != ZERO_REG) &&
                     ((idex_dst  == dec_rs) || (idex_dst  == dec_rt));
  assign exmem_hit = exmem_reg_wr && (exmem_dst != ZERO_REG) &&
                     ((exmem_dst == dec_rs) || (exmem_dst == dec_rt));

  assign load_use = idex_hit && idex_mem_rd;
  assign br_alu   = idex_hit && !idex_mem_rd && dec_is_branch;
  assign br_load2 = exmem_hit && exmem_mem_rd && dec_is_branch;
  assign hold     = !rst && (load_use || br_alu || br_load2);

  assign pc_we       = !hold;
  assign ifid_we     = !hold;
  assign idex_bubble = hold;
  assign ifid_flush  = !rst && !hold && dec_is_branch && br_taken;

  always_comb begin
    if (rst) assert_reset_idle_R1: assert (pc_we && ifid_we && !idex_bubble && !ifid_flush);
  end

  assert_load_use_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (idex_mem_rd && idex_reg_wr && idex_dst != ZERO_REG && idex_dst == dec_rs) |-> (idex_bubble && !pc_we));

  assert_nonbranch_ignores_alu_R4: assert property (@(posedge clk) disable iff (rst)
    (!dec_is_branch && !idex_mem_rd) |-> pc_we);

  assert_branch_load_two_R5: assert property (@(posedge clk) disable iff (rst)
    (dec_is_branch && exmem_mem_rd && exmem_reg_wr && exmem_dst != ZERO_REG && exmem_dst == dec_rt) |-> !ifid_we);

  assert_zero_dst_free_R8: assert property (@(posedge clk) disable iff (rst)
    (idex_dst == ZERO_REG && exmem_dst == ZERO_REG) |-> !idex_bubble);

  assert_no_writer_free_R9: assert property (@(posedge clk) disable iff (rst)
    (!idex_reg_wr && !exmem_reg_wr) |-> (pc_we && ifid_we));

  assert_flush_needs_branch_R10: assert property (@(posedge clk) disable iff (rst)
    ifid_flush |-> (dec_is_branch && br_taken && pc_we));

  assert_flush_not_while_held_R11: assert property (@(posedge clk) disable iff (rst)
    idex_bubble |-> !ifid_flush);

endmodule

// File: tb/sim_hazard_ctrl.sv
module sim_hazard_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] dec_rs, dec_rt, idex_dst, exmem_dst;
  logic       dec_is_branch, br_taken, idex_mem_rd, idex_reg_wr, exmem_mem_rd, exmem_reg_wr;
  logic       pc_we, ifid_we, idex_bubble, ifid_flush;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hazard_ctrl #(.REG_W(5)) u0 (
    .clk(clk), .rst(rst), .dec_rs(dec_rs), .dec_rt(dec_rt),
    .dec_is_branch(dec_is_branch), .br_taken(br_taken),
    .idex_mem_rd(idex_mem_rd), .idex_reg_wr(idex_reg_wr), .idex_dst(idex_dst),
    .exmem_mem_rd(exmem_mem_rd), .exmem_reg_wr(exmem_reg_wr), .exmem_dst(exmem_dst),
    .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [4:0] rs;  logic [4:0] rt;  logic br;  logic tk;
    logic       imr; logic       iwr; logic [4:0] idst;
    logic       emr; logic       ewr; logic [4:0] edst;
    logic       stall; logic flush;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{4'd2,  5'd5, 5'd1, 1'b0, 1'b0, 1'b1, 1'b1, 5'd5, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0}, // R2 rs match
    '{4'd2,  5'd1, 5'd5, 1'b0, 1'b0, 1'b1, 1'b1, 5'd5, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0}, // R2 rt match
    '{4'd2,  5'd6, 5'd7, 1'b0, 1'b0, 1'b1, 1'b1, 5'd5, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0}, // R2 no match
    '{4'd3,  5'd5, 5'd1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b1, 5'd5, 1'b0, 1'b0}, // R3
    '{4'd4,  5'd3, 5'd1, 1'b1, 1'b0, 1'b0, 1'b1, 5'd3, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0}, // R4 branch
    '{4'd4,  5'd3, 5'd1, 1'b0, 1'b0, 1'b0, 1'b1, 5'd3, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0}, // R4 non-branch
    '{4'd5,  5'd2, 5'd9, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b1, 5'd9, 1'b1, 1'b0}, // R5
    '{4'd7,  5'd9, 5'd2, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 5'd9, 1'b0, 1'b0}, // R7
    '{4'd8,  5'd0, 5'd4, 1'b0, 1'b0, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0}, // R8 load
    '{4'd8,  5'd0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b1, 5'd0, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0}, // R8 branch
    '{4'd9,  5'd5, 5'd1, 1'b0, 1'b0, 1'b1, 1'b0, 5'd5, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0}, // R9 idex
    '{4'd9,  5'd1, 5'd9, 1'b1, 1'b0, 1'b0, 1'b0, 5'd9, 1'b1, 1'b0, 5'd9, 1'b0, 1'b0}, // R9 exmem
    '{4'd10, 5'd1, 5'd2, 1'b1, 1'b1, 1'b0, 1'b1, 5'd7, 1'b1, 1'b1, 5'd8, 1'b0, 1'b1}, // R10
    '{4'd11, 5'd3, 5'd1, 1'b1, 1'b1, 1'b0, 1'b1, 5'd3, 1'b0, 1'b0, 5'd0, 1'b1, 1'b0}, // R11 held
    '{4'd11, 5'd1, 5'd2, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0}  // R11 not branch
  };

  task automatic apply(input vec_t v);
    @(negedge clk);
    dec_rs = v.rs; dec_rt = v.rt; dec_is_branch = v.br; br_taken = v.tk;
    idex_mem_rd = v.imr; idex_reg_wr = v.iwr; idex_dst = v.idst;
    exmem_mem_rd = v.emr; exmem_reg_wr = v.ewr; exmem_dst = v.edst;
    #5;
  endtask

  task automatic check(input string tag, input logic stall, input logic flush);
    logic [3:0] got, exp;
    got = {pc_we, ifid_we, idex_bubble, ifid_flush};
    exp = {!stall, !stall, stall, flush};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: pc_we/ifid_we/bubble/flush got %b expected %b", tag, got, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    // R1: reset with a live load-use hazard and a taken branch on the inputs
    apply('{4'd1, 5'd5, 5'd5, 1'b1, 1'b1, 1'b1, 1'b1, 5'd5, 1'b1, 1'b1, 5'd5, 1'b0, 1'b0});
    check("R1", 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      check($sformatf("R%0d vec %0d", TBL[i].req, i), TBL[i].stall, TBL[i].flush);
    end

    // R6: load r4 directly ahead of branch on r4, played as three cycles
    apply('{4'd6, 5'd4, 5'd0, 1'b1, 1'b0, 1'b1, 1'b1, 5'd4, 1'b0, 1'b1, 5'd12, 1'b0, 1'b0});
    check("R6 cycle 1", 1'b1, 1'b0);
    apply('{4'd6, 5'd4, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1, 1'b1, 5'd4, 1'b0, 1'b0});
    check("R6 cycle 2", 1'b1, 1'b0);
    apply('{4'd6, 5'd4, 5'd0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0});
    check("R6 cycle 3 advances and flushes", 1'b0, 1'b1);

    // R1: reset raised again over a stalling state
    apply('{4'd1, 5'd3, 5'd1, 1'b1, 1'b0, 1'b0, 1'b1, 5'd3, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0});
    check("R4 before reset", 1'b1, 1'b0);
    @(negedge clk); rst = 1'b1; #5;
    check("R1 reset overrides stall", 1'b0, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule